// File: doc/BRIEF.md
# Atomic Reservation Tracker

This block keeps the single reservation that pairs a load-reserve with a later store-conditional, and it sits in front of a cache's store path. A load-reserve records the cache line that its address falls in. A store-conditional then compares its own line against that record. On a mismatch, or when there is no reservation, the block cancels the store in the same cycle, so that neither the cache array nor the bus is written. On a match it lets the store through and waits for the write acknowledgement.

Every store-conditional ends with one completion pulse. The pulse carries a record flag, so that the first condition field is updated, and a store-done flag that tells whether the store happened. A failed attempt completes on the cycle after the request. A successful attempt completes on the cycle after its acknowledgement. Any store-conditional, whether it succeeds or fails, drops the reservation. The core issues no new request while a successful conditional store is still waiting for its acknowledgement.

Top module: `lsrv_guard`

## Requirements
- R1: After reset there is no reservation and no completion pulse, so the first store-conditional fails.
- R2: A load-reserve records the line, which is the address with its low LINE_W bits dropped. A store-conditional to that line then succeeds: `cancel_store_o`=0 and `store_go_o`=1 in the request cycle.
- R3: A store-conditional to a different line while a reservation is held asserts `cancel_store_o` and holds `store_go_o` low in the request cycle.
- R4: A store-conditional with no reservation held fails in the same way as R3.
- R5: A failed store-conditional produces a one-cycle pulse on the next cycle with `done_valid_o`=1, `done_rec_o`=1 and `done_stored_o`=0.
- R6: A successful store-conditional gives no completion until `wr_ack_i` arrives. One cycle after the acknowledgement it gives a one-cycle pulse with `done_valid_o`=1, `done_rec_o`=1 and `done_stored_o`=1.
- R7: Every store-conditional clears the reservation, whatever its outcome, so a second store-conditional fails.
- R8: A new load-reserve replaces the held line.
- R9: Plain loads (op 0) and plain stores (op 1) leave the reservation unchanged and raise no completion. A plain store always drives `store_go_o`=1 and `cancel_store_o`=0.
- R10: The reservation ignores the access size and the offset within the line. Any offset within the reserved line matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 0 load, 1 store, 2 load-reserve, 3 store-conditional |
| req_addr_i | input | ADDR_W | Byte address of the request |
| wr_ack_i | input | 1 | Write acknowledgement for a store that was let through |
| cancel_store_o | output | 1 | Suppress the cache write and the bus cycle (combinational) |
| store_go_o | output | 1 | Store may proceed to cache and bus (combinational) |
| done_valid_o | output | 1 | Store-conditional completion pulse |
| done_rec_o | output | 1 | Record flag: update the first condition field |
| done_stored_o | output | 1 | Store-done result of the store-conditional |

## Verification
The bench goes after several corner cases. The first is a store-conditional whose offset within the line differs from the load-reserve offset; a design that compared the full address would wrongly fail it. The second is a second store-conditional right after a successful one; a design that kept the reservation would let it write. The third is plain stores and loads placed between the pair; a design that cleared the reservation on them would turn a valid conditional into a failure. The bench also times both completion paths to the cycle. A design that completed a successful store before its acknowledgement, or that delayed a failed one, would update the condition field at the wrong point.

// File: rtl/lsrv_pkg.sv
package lsrv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LRES  = 2'd2,
    OP_SCOND = 2'd3
  } lsrv_op_e;
endpackage

// File: rtl/lsrv_resv.sv
module lsrv_resv #(
  parameter int TAG_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lr_i,
  input  logic             sc_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (lr_i) begin
      valid_q <= 1'b1;
      tag_q   <= tag_i;
    end else if (sc_i) begin
      valid_q <= 1'b0;
    end
  end

  assign hit_o = valid_q && (tag_q == tag_i);

  assert_lr_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_i |=> valid_q && tag_q == $past(tag_i));
  assert_sc_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_i && !lr_i) |=> !valid_q);
endmodule

// File: rtl/lsrv_cmpl.sv
module lsrv_cmpl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sc_fail_i,
  input  logic sc_ok_i,
  input  logic wr_ack_i,
  output logic done_valid_o,
  output logic done_rec_o,
  output logic done_stored_o
);
  logic pend_q, fail_q, ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      fail_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      fail_q <= sc_fail_i;
      ok_q   <= pend_q && wr_ack_i;
      if (sc_ok_i)                pend_q <= 1'b1;
      else if (pend_q && wr_ack_i) pend_q <= 1'b0;
    end
  end

  assign done_valid_o  = fail_q | ok_q;
  assign done_rec_o    = fail_q | ok_q;
  assign done_stored_o = ok_q;

  assert_fail_cmpl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_fail_i |=> done_valid_o && done_rec_o && !done_stored_o);
  assert_ok_cmpl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && wr_ack_i) |=> done_valid_o && done_stored_o);
  assert_no_early_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_ok_i |=> !done_valid_o);
endmodule

// File: rtl/lsrv_guard.sv
module lsrv_guard
  import lsrv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              wr_ack_i,
  output logic              cancel_store_o,
  output logic              store_go_o,
  output logic              done_valid_o,
  output logic              done_rec_o,
  output logic              done_stored_o
);
  localparam int TAG_W = ADDR_W - LINE_W;

  lsrv_op_e         op;
  logic             is_lr, is_sc, is_st, hit;
  logic [TAG_W-1:0] tag;
  logic             offs_unused;

  assign op          = lsrv_op_e'(req_op_i);
  assign tag         = req_addr_i[ADDR_W-1:LINE_W];
  assign offs_unused = ^req_addr_i[LINE_W-1:0];
  assign is_lr       = req_valid_i && (op == OP_LRES);
  assign is_sc       = req_valid_i && (op == OP_SCOND);
  assign is_st       = req_valid_i && (op == OP_STORE);

  lsrv_resv #(.TAG_W(TAG_W)) u_resv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lr_i   (is_lr),
    .sc_i   (is_sc),
    .tag_i  (tag),
    .hit_o  (hit)
  );

  // failed conditional kills both cache write and bus cycle
  assign cancel_store_o = is_sc && !hit;
  assign store_go_o     = is_st || (is_sc && hit);

  lsrv_cmpl u_cmpl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sc_fail_i     (is_sc && !hit),
    .sc_ok_i       (is_sc && hit),
    .wr_ack_i      (wr_ack_i),
    .done_valid_o  (done_valid_o),
    .done_rec_o    (done_rec_o),
    .done_stored_o (done_stored_o)
  );

  assert_cancel_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cancel_store_o && store_go_o));
  assert_plain_no_cancel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_op_i[1]) |-> !cancel_store_o);
endmodule

// File: tb/lsrv_guard_tb.sv
module lsrv_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic        wr_ack = 1'b0;
  logic        cancel_store, store_go, done_valid, done_rec, done_stored;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic        mv = 1'b0;
  logic [25:0] mline = '0;

  always #5 clk = ~clk;

  lsrv_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .wr_ack_i(wr_ack), .cancel_store_o(cancel_store),
    .store_go_o(store_go), .done_valid_o(done_valid), .done_rec_o(done_rec),
    .done_stored_o(done_stored)
  );

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", rq, what, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [31:0] a);
    return mv && (mline == a[31:6]);
  endfunction

  task automatic wait_ack(input int gap, input string rq);
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      chk(rq, "no done before ack", done_valid, 1'b0);
    end
    wr_ack = 1'b1;
    @(negedge clk);
    wr_ack = 1'b0;
    chk(rq, "ok done_valid", done_valid, 1'b1);
    chk(rq, "ok done_rec", done_rec, 1'b1);
    chk(rq, "ok done_stored", done_stored, 1'b1);
    @(negedge clk);
    chk(rq, "done one pulse", done_valid, 1'b0);
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input string rq);
    logic h, ec, eg;
    h  = exp_hit(a);
    ec = (op == 2'd3) && !h;
    eg = (op == 2'd1) || ((op == 2'd3) && h);
    req_valid = 1'b1; req_op = op; req_addr = a;
    #1;
    chk(rq, "cancel_store", cancel_store, ec);
    chk(rq, "store_go", store_go, eg);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rq, "done_valid", done_valid, ec);
    chk(rq, "done_rec", done_rec, ec);
    chk(rq, "done_stored", done_stored, 1'b0);
    if (op == 2'd2) begin mv = 1'b1; mline = a[31:6]; end
    if (op == 2'd3) mv = 1'b0;
    if ((op == 2'd3) && h) wait_ack(($urandom % 4), rq);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #23;
    @(negedge clk);
    chk("R1", "reset cancel", cancel_store, 1'b0);
    chk("R1", "reset done", done_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(2'd3, 32'h0000_1000, "R1");                 // fails, no reservation
    issue(2'd3, 32'h0000_1000, "R4");
    issue(2'd2, 32'h0000_1004, "R2");
    issue(2'd3, 32'h0000_103C, "R10");                // other offset, same line
    issue(2'd3, 32'h0000_1004, "R7");                 // reservation gone
    issue(2'd2, 32'h0000_2000, "R3");
    issue(2'd3, 32'h0000_2040, "R3");                 // adjacent line
    issue(2'd3, 32'h0000_2000, "R7");
    issue(2'd2, 32'h0000_3000, "R8");
    issue(2'd2, 32'h0000_4000, "R8");
    issue(2'd3, 32'h0000_3000, "R8");                 // old line lost
    issue(2'd2, 32'h0000_5008, "R9");
    issue(2'd1, 32'h0000_5008, "R9");
    issue(2'd0, 32'h0000_5010, "R9");
    issue(2'd1, 32'h0000_9000, "R9");
    issue(2'd3, 32'h0000_5000, "R9");                 // still held
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = {24'h0, 2'b0, 6'($urandom % 3), 6'($urandom)} << 0;
      a = {20'h0, 6'($urandom % 3), 6'($urandom)};
      issue(2'($urandom), a, "R2");
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule